// File: doc/BRIEF.md
# Universal Shift Register with Shared I/O

This block is an eight-bit storage register whose contents can be cleared, held, loaded in parallel or moved one place in either direction on each rising clock edge. A two-bit select picks the operation. An active-low synchronous clear takes priority over the select. Parallel data shares one set of bus pins for input and output. Here that bus is modelled as three signals: a bus input, a bus output and a bus output-enable that an enclosing pad or bus fabric uses to drive the wires.

Each end of the register has its own serial input. The lowest and highest bits also drive dedicated serial outputs, and these are never gated by the bus enables. Several registers can therefore be chained into one longer word: the high serial output feeds the next stage's right-shift input, and that stage's low serial output feeds back into this stage's left-shift input. The bus driver turns itself off whenever load is selected, so a load never fights the register's own output. Two active-low enable inputs give extra control over the bus driver.

Top module: `ushift_reg`

## Requirements
- R1: While the asynchronous system reset `rst_n` is low, every register bit is 0.
- R2: When `clr_n` is low at a rising edge, all bits become 0, whatever the value of `sel`.
- R3: With `clr_n` high and `sel` = 2'b11 (load), bit n takes `bus_in[n]` at the edge.
- R4: With `clr_n` high and `sel` = 2'b01 (shift right), bit 0 takes `ser_r_in` and each bit n>0 takes the old bit n-1.
- R5: With `clr_n` high and `sel` = 2'b10 (shift left), the top bit takes `ser_l_in` and each bit n below it takes the old bit n+1.
- R6: With `clr_n` high and `sel` = 2'b00 (hold), the contents do not change.
- R7: `bus_oe` is 1 exactly when `oe_a_n` and `oe_b_n` are both low and `sel` is not 2'b11. When `bus_oe` is 1, `bus_out` equals the register contents; otherwise `bus_out` is all zeros.
- R8: Clear, load, shift and hold work the same while `bus_oe` is 0.
- R9: `ser_lo_out` always equals bit 0 and `ser_hi_out` always equals the top bit, whatever the enable inputs are.
- R10: Two instances joined by their serial ports (high output to right input, low output to left input) shift as one word of twice the width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous system reset, active low |
| clr_n | input | 1 | Synchronous clear, active low, overrides sel |
| sel | input | 2 | Operation: 00 hold, 01 shift right, 10 shift left, 11 load |
| ser_r_in | input | 1 | Serial data into bit 0 on a right shift |
| ser_l_in | input | 1 | Serial data into the top bit on a left shift |
| oe_a_n | input | 1 | Bus output enable A, active low |
| oe_b_n | input | 1 | Bus output enable B, active low |
| bus_in | input | WIDTH | Parallel bus value seen on the shared pins |
| bus_out | output | WIDTH | Value to drive onto the shared pins |
| bus_oe | output | 1 | Drive enable for the shared pins |
| ser_lo_out | output | 1 | Bit 0, always driven |
| ser_hi_out | output | 1 | Top bit, always driven |

## Verification
On every cycle, the assertions check that a clear always empties the register, that load, hold and both shift directions move the previous cycle's bits into the right places, and that the bus driver is off whenever load is selected. The bench's scenarios are needed for the rest. They show that each operation behaves the same while the bus is disabled by either enable. They follow the serial end outputs as bits pass through them. They also carry data across two chained instances in both directions, which a property on one instance cannot see.

// File: rtl/ushr_pkg.sv
package ushr_pkg;
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_SHR   = 3'd1,
    OP_SHL   = 3'd2,
    OP_LOAD  = 3'd3,
    OP_CLEAR = 3'd4
  } op_e;

  localparam logic [1:0] SEL_HOLD = 2'b00;
  localparam logic [1:0] SEL_SHR  = 2'b01;
  localparam logic [1:0] SEL_SHL  = 2'b10;
  localparam logic [1:0] SEL_LOAD = 2'b11;
endpackage

// File: rtl/ushr_op_dec.sv
module ushr_op_dec
  import ushr_pkg::*;
(
  input  logic       clr_n,
  input  logic [1:0] sel,
  output op_e        op,
  output logic       upd,
  output logic       load_sel
);
  always_comb begin
    if (!clr_n) begin
      op = OP_CLEAR;
    end else begin
      case (sel)
        SEL_SHR:  op = OP_SHR;
        SEL_SHL:  op = OP_SHL;
        SEL_LOAD: op = OP_LOAD;
        default:  op = OP_HOLD;
      endcase
    end
  end

  // Clock enable: only hold leaves the flops idle.
  assign upd      = (op != OP_HOLD);
  // The bus driver looks at the raw select, not the clear-qualified op.
  assign load_sel = (sel == SEL_LOAD);
endmodule

// File: rtl/ushr_next.sv
module ushr_next
  import ushr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  op_e              op,
  input  logic [WIDTH-1:0] q,
  input  logic [WIDTH-1:0] bus_in,
  input  logic             ser_r_in,
  input  logic             ser_l_in,
  output logic [WIDTH-1:0] q_nxt
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] from_lo;
  logic [WIDTH-1:0] from_hi;

  for (genvar i = 0; i < WIDTH; i++) begin : g_nb
    if (i == 0) begin : g_lo_end
      assign from_lo[i] = ser_r_in;
    end else begin : g_lo_mid
      assign from_lo[i] = q[i-1];
    end
    if (i == TOP) begin : g_hi_end
      assign from_hi[i] = ser_l_in;
    end else begin : g_hi_mid
      assign from_hi[i] = q[i+1];
    end
  end

  always_comb begin
    case (op)
      OP_CLEAR: q_nxt = '0;
      OP_LOAD:  q_nxt = bus_in;
      OP_SHR:   q_nxt = from_lo;
      OP_SHL:   q_nxt = from_hi;
      default:  q_nxt = q;
    endcase
  end
endmodule

// File: rtl/ushr_bus_drv.sv
module ushr_bus_drv #(
  parameter int WIDTH = 8
) (
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  input  logic             load_sel,
  input  logic [WIDTH-1:0] q,
  output logic             bus_oe,
  output logic [WIDTH-1:0] bus_out
);
  always_comb begin
    bus_oe  = !oe_a_n && !oe_b_n && !load_sel;
    bus_out = bus_oe ? q : '0;
  end
endmodule

// File: rtl/ushift_reg.sv
module ushift_reg
  import ushr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic [1:0]       sel,
  input  logic             ser_r_in,
  input  logic             ser_l_in,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  input  logic [WIDTH-1:0] bus_in,
  output logic [WIDTH-1:0] bus_out,
  output logic             bus_oe,
  output logic             ser_lo_out,
  output logic             ser_hi_out
);
  localparam int TOP = WIDTH - 1;

  op_e              op;
  logic             upd;
  logic             load_sel;
  logic [WIDTH-1:0] q;
  logic [WIDTH-1:0] q_nxt;

  ushr_op_dec u_dec (
    .clr_n    (clr_n),
    .sel      (sel),
    .op       (op),
    .upd      (upd),
    .load_sel (load_sel)
  );

  ushr_next #(.WIDTH(WIDTH)) u_next (
    .op       (op),
    .q        (q),
    .bus_in   (bus_in),
    .ser_r_in (ser_r_in),
    .ser_l_in (ser_l_in),
    .q_nxt    (q_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (upd) begin
      q <= q_nxt;
    end
  end

  ushr_bus_drv #(.WIDTH(WIDTH)) u_bus (
    .oe_a_n   (oe_a_n),
    .oe_b_n   (oe_b_n),
    .load_sel (load_sel),
    .q        (q),
    .bus_oe   (bus_oe),
    .bus_out  (bus_out)
  );

  assign ser_lo_out = q[0];
  assign ser_hi_out = q[TOP];

  // R2: a clear empties the register regardless of sel
  p_clear_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (q == '0));

  // R3: load captures the bus
  p_load_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && sel == SEL_LOAD) |=> (q == $past(bus_in)));

  // R4: right shift
  p_shift_right_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && sel == SEL_SHR) |=> (q == {$past(q[TOP-1:0]), $past(ser_r_in)}));

  // R5: left shift
  p_shift_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && sel == SEL_SHL) |=> (q == {$past(ser_l_in), $past(q[TOP:1])}));

  // R6: hold keeps contents
  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && sel == SEL_HOLD) |=> $stable(q));

  // R7: never drive the bus while loading
  p_no_drive_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_LOAD) |-> !bus_oe);
endmodule

// File: tb/tb_ushift_reg.sv
module tb_ushift_reg;
  localparam int W = 8;

  typedef struct {
    logic [W-1:0] qa;
    logic [W-1:0] qb;
    logic         oe;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n, clr_n, sr_in, sl_in, oe_a_n, oe_b_n;
  logic [1:0]   sel;
  logic [W-1:0] bus_a, bus_b;
  logic [W-1:0] out_a, out_b;
  logic         oe_a, oe_b;
  logic         lo_a, hi_a, lo_b, hi_b;

  int n_checks = 0;
  int n_fail   = 0;
  exp_t sb[$];
  logic [W-1:0] ma, mb;
  bit done = 0;

  always #2.5 clk = ~clk;

  ushift_reg #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .sel(sel),
    .ser_r_in(sr_in), .ser_l_in(lo_b), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .bus_in(bus_a), .bus_out(out_a), .bus_oe(oe_a),
    .ser_lo_out(lo_a), .ser_hi_out(hi_a));

  ushift_reg #(.WIDTH(W)) dut2 (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .sel(sel),
    .ser_r_in(hi_a), .ser_l_in(sl_in), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .bus_in(bus_b), .bus_out(out_b), .bus_oe(oe_b),
    .ser_lo_out(lo_b), .ser_hi_out(hi_b));

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus, model it, queue the expectation.
  task automatic drive(logic c, logic [1:0] s, logic sr, logic sl,
                       logic ea, logic eb, logic [W-1:0] ba,
                       logic [W-1:0] bb, string tag);
    exp_t e;
    logic [W-1:0] na, nb;
    @(negedge clk);
    clr_n = c; sel = s; sr_in = sr; sl_in = sl;
    oe_a_n = ea; oe_b_n = eb; bus_a = ba; bus_b = bb;
    if (!c) begin
      na = '0; nb = '0;
    end else begin
      case (s)
        2'b01: begin na = {ma[W-2:0], sr};   nb = {mb[W-2:0], ma[W-1]}; end
        2'b10: begin na = {mb[0], ma[W-1:1]}; nb = {sl, mb[W-1:1]};    end
        2'b11: begin na = ba; nb = bb; end
        default: begin na = ma; nb = mb; end
      endcase
    end
    ma = na; mb = nb;
    e.qa = na; e.qb = nb; e.oe = !ea && !eb && (s != 2'b11); e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compare after each edge while the cycle's inputs are still applied.
  initial begin
    forever begin
      @(posedge clk); #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " bus"},  out_a, e.oe ? e.qa : '0);
        chk("R7 bus_oe", {{(W-1){1'b0}}, oe_a}, {{(W-1){1'b0}}, e.oe});
        chk("R9 lo/hi", {{(W-2){1'b0}}, hi_a, lo_a}, {{(W-2){1'b0}}, e.qa[W-1], e.qa[0]});
        chk("R10 stage2 bus", out_b, e.oe ? e.qb : '0);
        chk("R10 stage2 hi", {{(W-1){1'b0}}, hi_b}, {{(W-1){1'b0}}, e.qb[W-1]});
      end
    end
  end

  initial begin
    rst_n = 0; clr_n = 1; sel = 2'b00; sr_in = 0; sl_in = 0;
    oe_a_n = 0; oe_b_n = 0; bus_a = '0; bus_b = '0;
    ma = '0; mb = '0;
    fork
      begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset bus", out_a, '0);
        chk("R1 reset oe", {{(W-1){1'b0}}, oe_a}, {{(W-1){1'b0}}, 1'b1});
        @(negedge clk); rst_n = 1;
        drive(1, 2'b11, 0, 0, 0, 0, 8'hA5, 8'h3C, "R3 load");
        drive(1, 2'b00, 0, 0, 0, 0, 8'hFF, 8'hFF, "R6 hold");
        drive(1, 2'b00, 1, 1, 0, 0, 8'h00, 8'h00, "R6 hold");
        for (int i = 0; i < 10; i++)
          drive(1, 2'b01, i[0], 0, 0, 0, 8'h00, 8'h00, "R4 shr");
        for (int i = 0; i < 10; i++)
          drive(1, 2'b10, 0, (i % 3) == 0, 0, 0, 8'h00, 8'h00, "R5 shl");
        drive(0, 2'b11, 1, 1, 0, 0, 8'hFF, 8'hFF, "R2 clear");
        drive(1, 2'b00, 0, 0, 0, 0, 8'h00, 8'h00, "R2 after");
        drive(1, 2'b11, 0, 0, 1, 0, 8'h81, 8'h7E, "R8 load off");
        drive(1, 2'b01, 1, 0, 1, 0, 8'h00, 8'h00, "R8 shr off");
        drive(1, 2'b10, 0, 1, 0, 1, 8'h00, 8'h00, "R8 shl off");
        drive(1, 2'b00, 0, 0, 0, 0, 8'h00, 8'h00, "R8 view");
        drive(0, 2'b01, 1, 1, 1, 1, 8'h00, 8'h00, "R8 clear off");
        drive(1, 2'b00, 0, 0, 0, 0, 8'h00, 8'h00, "R8 view2");
        drive(1, 2'b11, 0, 0, 0, 0, 8'h5A, 8'hC3, "R3 load2");
        drive(1, 2'b01, 0, 0, 0, 1, 8'h00, 8'h00, "R9 shr off");
        drive(1, 2'b00, 0, 0, 0, 0, 8'h00, 8'h00, "R6 hold2");
        repeat (3) @(posedge clk);
        done = 1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          n_checks++; n_fail++;
          $display("FAIL watchdog: actual timeout expected completion");
        end
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule